// File: doc/BRIEF.md
# Read-Only Conversion Result Serial Slave

This block is the two-wire serial bus slave in front of a data converter whose only bus operation is reading its latest result. It samples the bus clock and data lines on a fast system clock, recognises bus conditions, and checks the 7-bit device address that follows a start. The address is set by a strap input. The slave acknowledges a read only when the converter reports a finished result. It then sends that 16-bit word as two bytes, most significant bit first, and asks the converter for a fresh conversion once the word has gone out or the master stops mid-word.

The data line is driven only as an open-drain pull-low enable. The result word is captured when the address is accepted, so the converter may update its output during the transfer without affecting it. A repeated start during the data phase abandons the word without requesting a conversion, so the master can read the same result again.

States: `S_IDLE` (not selected), `S_ADDR` (taking in address and direction bits on SCL rises), `S_ACKW` (address accepted, waiting for the 8th SCL fall), `S_ACK` (pulling the 9th bit low), `S_DATA` (driving a result bit per SCL low phase), `S_MACK` (released for the master's acknowledge clock). Transitions: a start goes from any state to `S_ADDR`; a stop goes from any state to `S_IDLE`; `S_ADDR`→`S_ACKW` on the 8th rise with a match, a read, and a ready result, otherwise `S_ADDR`→`S_IDLE`; `S_ACKW`→`S_ACK`→`S_DATA` on SCL falls; `S_DATA`→`S_MACK` on the 8th fall; `S_MACK`→`S_DATA` after the first byte, and `S_MACK`→`S_IDLE` with a conversion request after the second.

Top module: `rdonly_result_slave`

## Requirements
- R1: SDA falling while SCL is high is a start. From any state it begins a fresh address phase. A repeated start in the data phase abandons the word, requests no conversion, and leaves the same result readable again.
- R2: SDA rising while SCL is high is a stop. It returns the slave to idle, and the slave releases SDA from the next cycle on.
- R3: The accepted address is 0010100 when `addr_strap_i` is 0 and 1010100 when it is 1. Any other address leaves SDA released in the 9th clock (NAK), and the data bytes that follow read as all ones.
- R4: A direction bit of 0 (write) after a matching address is answered with a NAK.
- R5: A matching read while `result_ready_i` is 0 gets a NAK. When `result_ready_i` is 1 the slave pulls SDA low in the 9th clock (ACK).
- R6: After the ACK, the slave sends 16 result bits MSB first, high byte then low byte. A 0 bit pulls SDA low and a 1 bit releases it. SDA is released during each master acknowledge clock.
- R7: Apart from the cycle after a start or stop, the slave changes its SDA drive only while SCL is low. Bits advance on SCL falling edges.
- R8: The result word is captured when the address is accepted. Later changes on `result_data_i` do not alter the bytes sent.
- R9: `conv_start_o` is a one-cycle pulse. It fires after the master acknowledge clock of the second byte, or on a stop during the data phase. A NAK'd address gives no pulse.
- R10: After reset SDA is released and `conv_start_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| sda_pull_o | output | 1 | Open-drain enable: 1 pulls SDA low |
| addr_strap_i | input | 1 | Strap selecting one of two device addresses |
| result_ready_i | input | 1 | Converter has a finished result |
| result_data_i | input | 16 | Converter result word |
| conv_start_o | output | 1 | One-cycle request to begin a new conversion |

## Verification
The assertions check on every cycle that the SDA drive holds steady through each SCL high phase except right after a bus condition. They also check that a stop releases the line, that a start restarts the address phase at bit zero, that a not-ready match falls back to idle, and that the conversion request never lasts two cycles. The bench scenarios are needed for the rest: the address values for each strap setting, the byte order and bit values sent, the result staying fixed while the input changes, the NAK cases, and whether a conversion request appears or not after a full read, a stop in the middle, or a repeated start.

// File: rtl/rdonly_result_pkg.sv
package rdonly_result_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR,
        S_ACKW,
        S_ACK,
        S_DATA,
        S_MACK
    } slv_state_t;
endpackage

// File: rtl/rr_bus_sampler.sv
module rr_bus_sampler #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    logic [STAGES-1:0] scl_sr;
    logic [STAGES-1:0] sda_sr;
    logic              scl_q;
    logic              sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sr <= '1;
            sda_sr <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_sr <= {scl_sr[STAGES-2:0], scl_i};
            sda_sr <= {sda_sr[STAGES-2:0], sda_i};
            scl_q  <= scl_sr[STAGES-1];
            sda_q  <= sda_sr[STAGES-1];
        end
    end

    assign scl_o      = scl_sr[STAGES-1];
    assign sda_o      = sda_sr[STAGES-1];
    assign scl_rise_o = scl_o && !scl_q;
    assign scl_fall_o = !scl_o && scl_q;
    assign start_o    = scl_o && scl_q && sda_q && !sda_o;
    assign stop_o     = scl_o && scl_q && !sda_q && sda_o;
endmodule

// File: rtl/rr_tx_shifter.sv
module rr_tx_shifter #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift,
    input  logic [DATA_W-1:0] data_in,
    output logic              msb_o
);
    logic [DATA_W-1:0] sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     sr <= '1;
        else if (load)  sr <= data_in;
        else if (shift) sr <= {sr[DATA_W-2:0], 1'b1};
    end

    assign msb_o = sr[DATA_W-1];
endmodule

// File: rtl/rdonly_result_slave.sv
module rdonly_result_slave
    import rdonly_result_pkg::*;
#(
    parameter int         DATA_W      = 16,
    parameter int         SYNC_STAGES = 2,
    parameter logic [6:0] ADDR_STRAP0 = 7'b0010100,
    parameter logic [6:0] ADDR_STRAP1 = 7'b1010100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_pull_o,
    input  logic              addr_strap_i,
    input  logic              result_ready_i,
    input  logic [DATA_W-1:0] result_data_i,
    output logic              conv_start_o
);
    localparam int BYTES = DATA_W / 8;
    localparam int BW    = (BYTES > 1) ? $clog2(BYTES) : 1;

    slv_state_t      state;
    logic [2:0]      bit_cnt;
    logic [BW-1:0]   byte_idx;
    logic [6:0]      addr_sr;
    logic            conv_q;
    logic            s_scl, s_sda, scl_rise, scl_fall, start_det, stop_det;
    logic            tx_msb, tx_load, tx_shift, addr_hit;
    logic [6:0]      own_addr;

    rr_bus_sampler #(.STAGES(SYNC_STAGES)) u_samp (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_o(s_scl), .sda_o(s_sda), .scl_rise_o(scl_rise),
        .scl_fall_o(scl_fall), .start_o(start_det), .stop_o(stop_det)
    );

    assign own_addr = addr_strap_i ? ADDR_STRAP1 : ADDR_STRAP0;
    assign addr_hit = (addr_sr == own_addr) && s_sda && result_ready_i;
    assign tx_load  = (state == S_ADDR) && scl_rise && (bit_cnt == 3'd7)
                      && addr_hit && !start_det && !stop_det;
    assign tx_shift = (state == S_DATA) && scl_fall && !start_det && !stop_det;

    rr_tx_shifter #(.DATA_W(DATA_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .load(tx_load), .shift(tx_shift),
        .data_in(result_data_i), .msb_o(tx_msb)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            bit_cnt  <= '0;
            byte_idx <= '0;
            addr_sr  <= '0;
            conv_q   <= 1'b0;
        end else begin
            conv_q <= 1'b0;
            if (start_det) begin
                state   <= S_ADDR;
                bit_cnt <= '0;
            end else if (stop_det) begin
                if (state == S_DATA || state == S_MACK) conv_q <= 1'b1;
                state <= S_IDLE;
            end else begin
                unique case (state)
                    S_IDLE: ;
                    S_ADDR: if (scl_rise) begin
                        bit_cnt <= bit_cnt + 3'd1;
                        if (bit_cnt == 3'd7) state <= addr_hit ? S_ACKW : S_IDLE;
                        else                 addr_sr <= {addr_sr[5:0], s_sda};
                    end
                    S_ACKW: if (scl_fall) state <= S_ACK;
                    S_ACK: if (scl_fall) begin
                        state    <= S_DATA;
                        bit_cnt  <= '0;
                        byte_idx <= '0;
                    end
                    S_DATA: if (scl_fall) begin
                        bit_cnt <= bit_cnt + 3'd1;
                        if (bit_cnt == 3'd7) state <= S_MACK;
                    end
                    S_MACK: if (scl_fall) begin
                        bit_cnt <= '0;
                        if (byte_idx == BW'(BYTES - 1)) begin
                            state  <= S_IDLE;
                            conv_q <= 1'b1;
                        end else begin
                            state    <= S_DATA;
                            byte_idx <= byte_idx + BW'(1);
                        end
                    end
                    default: state <= S_IDLE;
                endcase
            end
        end
    end

    // Outputs
    always_comb begin
        sda_pull_o   = (state == S_ACK) || (state == S_DATA && !tx_msb);
        conv_start_o = conv_q;
    end

    // R7: drive holds during SCL high unless a condition just occurred
    a_r7_stable_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
        (s_scl && $past(s_scl) && !$past(start_det) && !$past(stop_det))
        |-> $stable(sda_pull_o));

    // R2: stop releases the line
    a_r2_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_pull_o);

    // R1: start restarts the address phase
    a_r1_start_addr: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == S_ADDR && bit_cnt == 3'd0));

    // R5: a read while not ready falls back to idle
    a_r5_nak_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ADDR && scl_rise && bit_cnt == 3'd7 && !result_ready_i
         && !start_det && !stop_det) |=> (state == S_IDLE));

    // R9: conversion request lasts one cycle
    a_r9_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start_o |=> !conv_start_o);
endmodule

// File: tb/test_rdonly_result_slave.sv
module test_rdonly_result_slave;
    localparam int Q = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        strap = 1'b0;
    logic        ready = 1'b0;
    logic [15:0] rdata = 16'h0000;
    logic        sda_pull;
    logic        conv_start;
    wire         sda_bus = sda_m & ~sda_pull;

    int tests = 0;
    int fails = 0;
    int conv_cnt = 0;
    int r7_viol = 0;
    bit cond_ok = 1'b0;
    bit done = 1'b0;
    logic pull_prev = 1'b0;

    always #2 clk = ~clk;

    rdonly_result_slave i_rdonly_result_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
        .sda_pull_o(sda_pull), .addr_strap_i(strap),
        .result_ready_i(ready), .result_data_i(rdata),
        .conv_start_o(conv_start)
    );

    always @(negedge clk) begin
        if (conv_start) conv_cnt++;
        if (scl_m && !cond_ok && sda_pull !== pull_prev) r7_viol++;
        pull_prev = sda_pull;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wq(); repeat (Q) @(posedge clk); endtask

    task automatic bus_start();
        cond_ok = 1'b1;
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq();
        sda_m = 1'b0; wq(); scl_m = 1'b0; wq(); wq();
        cond_ok = 1'b0;
    endtask

    task automatic bus_stop();
        cond_ok = 1'b1;
        sda_m = 1'b0; wq(); scl_m = 1'b1; wq();
        sda_m = 1'b1; wq(); wq();
        cond_ok = 1'b0;
    endtask

    task automatic clk_bit(input logic b, output logic seen);
        wq(); sda_m = b; wq(); scl_m = 1'b1; wq();
        seen = sda_bus; wq(); scl_m = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ackb);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(v[i], s);
        clk_bit(1'b1, ackb);
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] v);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, s);
            v[i] = s;
        end
        clk_bit(mack, s);
    endtask

    task automatic t_reset();
        check("R10 sda released", {31'd0, sda_pull}, 0);
        check("R10 no pulse", {31'd0, conv_start}, 0);
    endtask

    task automatic t_full_read(input logic st, input logic [6:0] a, input logic [15:0] w);
        logic ackb; logic [7:0] hi, lo; int c0;
        strap = st; rdata = w; ready = 1'b1; c0 = conv_cnt;
        bus_start();
        send_byte({a, 1'b1}, ackb);
        check("R5/R3 address ACK", {31'd0, ackb}, 0);
        rdata = ~w;  // R8: input changes after capture
        recv_byte(1'b0, hi);
        recv_byte(1'b1, lo);
        check("R6/R8 high byte", {24'd0, hi}, {24'd0, w[15:8]});
        check("R6/R8 low byte", {24'd0, lo}, {24'd0, w[7:0]});
        repeat (4) @(posedge clk);
        check("R9 one pulse after 16 bits", conv_cnt - c0, 1);
        bus_stop();
        check("R9 no pulse on stop after read", conv_cnt - c0, 1);
        ready = 1'b0;
    endtask

    task automatic t_nak(input string req, input logic [7:0] first, input logic rdy);
        logic ackb; logic [7:0] v; int c0;
        strap = 1'b0; ready = rdy; rdata = 16'h1234; c0 = conv_cnt;
        bus_start();
        send_byte(first, ackb);
        check(req, {31'd0, ackb}, 1);
        recv_byte(1'b1, v);
        check({req, " bus stays released"}, {24'd0, v}, 32'hFF);
        bus_stop();
        check({req, " no pulse"}, conv_cnt - c0, 0);
    endtask

    task automatic t_restart();
        logic ackb; logic [7:0] hi, lo; int c0;
        strap = 1'b0; ready = 1'b1; rdata = 16'hC3A5; c0 = conv_cnt;
        bus_start();
        send_byte(8'b0010100_1, ackb);
        recv_byte(1'b0, hi);
        bus_start();  // repeated start while bit 7 (=1) is driven
        check("R1 no pulse on repeated start", conv_cnt - c0, 0);
        send_byte(8'b0010100_1, ackb);
        check("R1 re-read ACK", {31'd0, ackb}, 0);
        recv_byte(1'b0, hi);
        recv_byte(1'b1, lo);
        check("R1 re-read word", {16'd0, hi, lo}, 32'hC3A5);
        bus_stop();
        check("R1 one pulse overall", conv_cnt - c0, 1);
        ready = 1'b0;
    endtask

    task automatic t_stop_mid();
        logic ackb; logic [7:0] hi; int c0;
        strap = 1'b1; ready = 1'b1; rdata = 16'h81FF; c0 = conv_cnt;
        bus_start();
        send_byte(8'b1010100_1, ackb);
        recv_byte(1'b0, hi);
        check("R6 first byte", {24'd0, hi}, 32'h81);
        bus_stop();
        check("R2 released after stop", {31'd0, sda_pull}, 0);
        check("R9 pulse on stop in data", conv_cnt - c0, 1);
        ready = 1'b0;
    endtask

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (5) @(posedge clk);
        t_full_read(1'b0, 7'b0010100, 16'hA55A);
        t_full_read(1'b1, 7'b1010100, 16'h0F81);
        t_nak("R3 wrong address", 8'b1010100_1, 1'b1);
        t_nak("R4 write NAK", 8'b0010100_0, 1'b1);
        t_nak("R5 not ready NAK", 8'b0010100_1, 1'b0);
        t_restart();
        t_stop_mid();
        check("R7 drive changes in SCL high", r7_viol, 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule